// File: doc/BRIEF.md
# 2:4 Magnitude Pruner and Compressor

This block turns a stream of dense weight groups into a compressed two-of-four form. Each input beat carries four signed weights. The block keeps the two weights with the largest absolute value and drops the other two. It then emits the two survivors in lane order. Each survivor comes with its 2-bit lane number, so a consumer can rebuild the pruned group exactly.

A flag travels with each output beat. It is set when pruning threw away at least one nonzero weight, which means the group did not already satisfy the two-of-four rule. Both sides use valid/ready handshakes. The pipeline accepts one group per cycle and has a latency of two cycles when the output is not stalled.

Top module: `sparse24_pruner`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `out_valid` is 0.
- R2: The two kept lanes are the two with the largest magnitude. Magnitude is the absolute value of the two's-complement weight, and the most negative code ranks above every other value. Lane i is `in_w[i*W +: W]`.
- R3: When magnitudes are equal, the lane with the lower index ranks higher. An all-zero group therefore keeps lanes 0 and 1.
- R4: `out_idx0` and `out_idx1` are the 2-bit lane numbers of the kept weights, and `out_idx0 < out_idx1` whenever `out_valid` is 1.
- R5: `out_val0` and `out_val1` are the unmodified signed weights from lanes `out_idx0` and `out_idx1`.
- R6: `out_lossy` is 1 exactly when at least one of the two discarded lanes held a nonzero weight.
- R7: While `out_valid` is 1 and `out_ready` is 0, every output holds its value. Groups leave in the order they arrived, with none lost or repeated. Once two groups are waiting, `in_ready` drops to 0.
- R8: Whenever `out_ready` is 1, `in_ready` is 1, so one group per cycle passes through.
- R9: A group accepted in cycle k appears on the outputs in cycle k+2 if `out_ready` is 1 in cycle k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input group is valid |
| in_ready | output | 1 | Block can accept a group |
| in_w | input | 4*W | Four signed weights, lane i at bits [i*W +: W] |
| out_valid | output | 1 | Output beat is valid |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_val0 | output | W | Kept weight with the lower lane number |
| out_val1 | output | W | Kept weight with the higher lane number |
| out_idx0 | output | 2 | Lane number of out_val0 |
| out_idx1 | output | 2 | Lane number of out_val1 |
| out_lossy | output | 1 | A nonzero weight was discarded |

## Verification
A wrong rank or keep mask in the first stage shows up two cycles after acceptance, as a wrong lane number or value, or as a flipped lossy flag on that group's output beat. A slip in the handshake registers shows up as outputs changing during a stall, or as a group lost or repeated in the output order. The comparison against the expected queue catches both, on the first beat that leaves. The most negative code, ties and all-zero groups are driven on purpose, because a faulty magnitude or tie rule only shows on those inputs.

// File: rtl/sparse24_pruner.sv
module sparse24_pruner #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [4*W-1:0] in_w,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_val0,
  output logic [W-1:0]   out_val1,
  output logic [1:0]     out_idx0,
  output logic [1:0]     out_idx1,
  output logic           out_lossy
);

  logic [W-1:0] lane [4];
  logic [W-1:0] mag  [4];
  logic [1:0]   rank [4];
  logic [3:0]   keep, nz;

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_lane
      assign lane[g] = in_w[g*W +: W];
      assign mag[g]  = lane[g][W-1] ? (~lane[g] + 1'b1) : lane[g];
      assign nz[g]   = |lane[g];
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      rank[i] = 2'd0;
      for (int j = 0; j < 4; j++)
        if (j != i && (mag[j] > mag[i] || (mag[j] == mag[i] && j < i)))
          rank[i] = rank[i] + 2'd1;
      keep[i] = (rank[i] < 2'd2);
    end
  end

  logic           s1_v;
  logic [4*W-1:0] s1_w;
  logic [3:0]     s1_keep;
  logic           s1_lossy;
  logic           s1_go, s2_go;

  assign s2_go    = s1_v && (!out_valid || out_ready);
  assign in_ready = !s1_v || !out_valid || out_ready;
  assign s1_go    = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_w     <= '0;
      s1_keep  <= '0;
      s1_lossy <= 1'b0;
    end else begin
      if (s1_go) begin
        s1_w     <= in_w;
        s1_keep  <= keep;
        s1_lossy <= |(nz & ~keep);
      end
      if (in_ready) s1_v <= in_valid;
    end
  end

  logic [1:0] sel0, sel1;
  assign sel0 = s1_keep[0] ? 2'd0 : (s1_keep[1] ? 2'd1 : 2'd2);
  assign sel1 = s1_keep[3] ? 2'd3 : (s1_keep[2] ? 2'd2 : 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_val0  <= '0;
      out_val1  <= '0;
      out_idx0  <= 2'd0;
      out_idx1  <= 2'd1;
      out_lossy <= 1'b0;
    end else begin
      if (s2_go) begin
        out_val0  <= s1_w[sel0*W +: W];
        out_val1  <= s1_w[sel1*W +: W];
        out_idx0  <= sel0;
        out_idx1  <= sel1;
        out_lossy <= s1_lossy;
      end
      if (!out_valid || out_ready) out_valid <= s1_v;
    end
  end

endmodule

// File: rtl/sparse24_pruner_chk.sv
module sparse24_pruner_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_val0,
  input logic [W-1:0] out_val1,
  input logic [1:0]   out_idx0,
  input logic [1:0]   out_idx1,
  input logic         out_lossy
);

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !out_valid);

  a_r4_idx_order: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_idx0 < out_idx1));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_val0) && $stable(out_val1)
      && $stable(out_idx0) && $stable(out_idx1) && $stable(out_lossy)));

  a_r8_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready |=> out_valid);

endmodule

bind sparse24_pruner sparse24_pruner_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_val0(out_val0),
  .out_val1(out_val1), .out_idx0(out_idx0), .out_idx1(out_idx1),
  .out_lossy(out_lossy)
);

// File: tb/tb_sparse24_pruner.sv
module tb_sparse24_pruner;
  localparam int W = 8;
  localparam int RW = 2*W + 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [4*W-1:0] in_w = '0;
  logic           out_valid;
  logic           out_ready = 1'b0;
  logic [W-1:0]   out_val0, out_val1;
  logic [1:0]     out_idx0, out_idx1;
  logic           out_lossy;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [RW-1:0] exp_q [$];

  always #2 clk = ~clk;

  sparse24_pruner #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_w(in_w), .out_valid(out_valid), .out_ready(out_ready),
    .out_val0(out_val0), .out_val1(out_val1), .out_idx0(out_idx0),
    .out_idx1(out_idx1), .out_lossy(out_lossy)
  );

  function automatic int absv(logic [W-1:0] v);
    int s = $signed(v);
    return (s < 0) ? -s : s;
  endfunction

  function automatic logic [RW-1:0] ref_out(logic [4*W-1:0] g);
    int first = 0, second = -1, lo, hi;
    logic lossy = 0;
    for (int i = 1; i < 4; i++)
      if (absv(g[i*W +: W]) > absv(g[first*W +: W])) first = i;
    for (int i = 0; i < 4; i++)
      if (i != first && (second < 0 || absv(g[i*W +: W]) > absv(g[second*W +: W])))
        second = i;
    lo = (first < second) ? first : second;
    hi = (first < second) ? second : first;
    for (int i = 0; i < 4; i++)
      if (i != lo && i != hi && g[i*W +: W] != '0) lossy = 1;
    return {lossy, 2'(hi), 2'(lo), g[hi*W +: W], g[lo*W +: W]};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [4*W-1:0] w, bit rdy);
    logic [RW-1:0] e;
    @(negedge clk);
    in_valid = v; in_w = w; out_ready = rdy;
    #1;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R7", "unexpected output beat", 1, 0);
      end else begin
        e = exp_q.pop_front();
        check(out_idx0 == e[2*W +: 2] && out_idx1 == e[2*W+2 +: 2], "R2",
              "kept lanes {idx1,idx0}", {out_idx1, out_idx0}, e[2*W +: 4]);
        check(out_val0 == e[0 +: W] && out_val1 == e[W +: W], "R5",
              "kept values {val1,val0}", {out_val1, out_val0}, e[0 +: 2*W]);
        check(out_lossy == e[RW-1], "R6", "lossy flag", out_lossy, e[RW-1]);
      end
    end
    if (in_valid && in_ready) exp_q.push_back(ref_out(w));
  endtask

  function automatic logic [4*W-1:0] grp(int a, int b, int c, int d);
    return {W'(d), W'(c), W'(b), W'(a)};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [4*W+6:0] snap;
    logic [4*W-1:0] rw;
    void'($urandom(32'd24));
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    #1 check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);

    // R9 latency with an idle pipe
    step(1, grp(1, -3, 2, 7), 1);
    step(0, '0, 1);
    check(out_valid == 0, "R9", "valid one cycle after accept", out_valid, 0);
    step(0, '0, 1);
    check(out_valid == 1, "R9", "valid two cycles after accept", out_valid, 1);
    step(0, '0, 1);

    // directed corners: R2 most negative code, R3 ties, R6 conforming groups
    step(1, grp(127, -128, 5, 0), 1);
    step(1, grp(0, 0, 0, 0), 1);
    step(1, grp(5, -5, 5, -5), 1);
    step(1, grp(0, 9, 0, -4), 1);
    step(1, grp(0, 0, 0, 3), 1);
    step(1, grp(-128, -128, -128, 1), 1);
    step(1, grp(2, 2, 3, 3), 1);
    step(1, grp(-1, 0, 1, 0), 1);
    check(in_ready == 1, "R8", "in_ready with out_ready high", in_ready, 1);
    repeat (3) step(0, '0, 1);

    // R7 backpressure: fill, freeze, release
    step(1, grp(10, 20, 30, 40), 1);
    step(1, grp(-50, 1, 2, 60), 0);
    step(1, grp(4, 3, 2, 1), 0);
    snap = {out_val0, out_val1, out_idx0, out_idx1, out_lossy};
    repeat (4) step(1, grp(9, 9, 9, 9), 0);
    check(snap == {out_val0, out_val1, out_idx0, out_idx1, out_lossy}, "R7",
          "outputs held under stall", 0, 0);
    check(in_ready == 0, "R7", "in_ready with two groups waiting", in_ready, 0);
    repeat (4) step(0, '0, 1);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      for (int k = 0; k < 4; k++) begin
        int mode = $urandom_range(0, 3);
        int v;
        if (mode == 0) v = 0;
        else if (mode == 1) v = $urandom_range(0, 6) - 3;
        else v = $urandom_range(0, 255) - 128;
        rw[k*W +: W] = W'(v);
      end
      step($urandom_range(0, 3) != 0, rw, $urandom_range(0, 3) != 0);
    end
    repeat (6) step(0, '0, 1);
    check(exp_q.size() == 0, "R7", "groups left undelivered", exp_q.size(), 0);
    finish_run();
  end
endmodule